// File: doc/BRIEF.md
# Two-Dimensional Bus Request Arbiter

This block picks one winner among pending bus requests that each carry two priority coordinates: an arbitration level (four interrupt levels and one direct-memory-access level) and a backplane slot. Each level holds its own bit vector of active slots. A priority encoder finds the lowest active slot of every level, and all levels are encoded in parallel. A level selector then takes the highest level that has any slot active.

A requester raises its request by presenting a level index and a slot number with a one-cycle set strobe. The arbiter registers the winner as a grant. The grant reports valid, level index, slot number, a one-hot slot vector, the bus interrupt level and a DMA flag. The grant stays in place until the consumer pulses `complete`. That pulse clears the granted request bit, and a new winner is then chosen, so no more than one grant is ever outstanding.

Top module: `bus_req_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `grant_valid` is 0, `grant_level`, `grant_slot`, `grant_slot_onehot`, `grant_intr_level` and `grant_is_dma` are all 0, and no request is pending.
- R2: Level index encoding is 0 = interrupt level 4, 1 = level 5, 2 = level 6, 3 = level 7 and 4 = DMA. Between pending requests of different levels, the one with the larger level index is granted, so DMA beats every interrupt level.
- R3: Within one level, the pending request with the smallest slot number (0 to 31) is granted first.
- R4: A set strobe captured at a clock edge makes its request pending at that edge. When no grant is outstanding, the grant appears at the following edge, never at the same one. A grant always refers to a pending request.
- R5: While a grant is outstanding and `complete` is low, the grant outputs hold their values, even when requests of higher priority arrive.
- R6: `complete` sampled high while a grant is outstanding clears the granted request bit and drops `grant_valid` at that edge. The next pending winner, if any, is granted at the edge after that.
- R7: Setting a request that is already pending has no effect. One `complete` removes it, however many times it was set.
- R8: Whenever `grant_valid` is 0, `grant_level`, `grant_slot`, `grant_slot_onehot`, `grant_intr_level` and `grant_is_dma` are 0.
- R9: For a granted interrupt level (index 0 to 3), `grant_intr_level` equals the index plus 4 and `grant_is_dma` is 0. For the DMA level (index 4), `grant_intr_level` is 0 and `grant_is_dma` is 1.
- R10: While `grant_valid` is 1, `grant_slot_onehot` has exactly one bit set, at position `grant_slot`.
- R11: `complete` sampled high while no grant is outstanding is ignored and clears no pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | 1 | One-cycle strobe that registers a request |
| req_level | input | 3 | Level index of the request being set |
| req_slot | input | 5 | Slot number of the request being set |
| complete | input | 1 | Ends the outstanding grant and clears its request bit |
| grant_valid | output | 1 | A grant is outstanding |
| grant_level | output | 3 | Level index of the grant |
| grant_slot | output | 5 | Slot number of the grant |
| grant_slot_onehot | output | 32 | One-hot form of the granted slot |
| grant_intr_level | output | 4 | Bus interrupt level (index + 4), 0 for DMA |
| grant_is_dma | output | 1 | The grant belongs to the DMA level |

## Verification
The bound checker tests several rules on every cycle. Idle outputs must be zero. The one-hot slot vector must agree with the slot number. The interrupt level and DMA flag must match the level index. A grant must always point at a pending bit. A grant must stay stable until `complete`, and it must drop right after `complete`. Only the bench scenarios can show that the right winner is chosen: the level-over-slot ordering across mixed request sets, the one-cycle grant latency, the fact that duplicate sets do not count up, and the fact that a stray `complete` clears no request.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int DEF_LEVELS  = 5;
  localparam int DEF_SLOTS   = 32;
  localparam int INTR_OFFSET = 4;

  typedef enum logic [2:0] {
    LVL_INTR4 = 3'd0,
    LVL_INTR5 = 3'd1,
    LVL_INTR6 = 3'd2,
    LVL_INTR7 = 3'd3,
    LVL_DMA   = 3'd4
  } arb_level_e;
endpackage

// File: rtl/arb_pending_bank.sv
module arb_pending_bank #(
  parameter int NUM_LEVELS = arb_pkg::DEF_LEVELS,
  parameter int NUM_SLOTS  = arb_pkg::DEF_SLOTS,
  localparam int LVL_W  = $clog2(NUM_LEVELS),
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  set_en,
  input  logic [LVL_W-1:0]                      set_level,
  input  logic [SLOT_W-1:0]                     set_slot,
  input  logic                                  clr_en,
  input  logic [LVL_W-1:0]                      clr_level,
  input  logic [SLOT_W-1:0]                     clr_slot,
  output logic [NUM_LEVELS-1:0][NUM_SLOTS-1:0]  pend
);
  logic [NUM_SLOTS-1:0] set_mask;
  logic [NUM_SLOTS-1:0] clr_mask;

  always_comb begin
    set_mask = NUM_SLOTS'(1) << set_slot;
    clr_mask = NUM_SLOTS'(1) << clr_slot;
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
    logic                 hit_set;
    logic                 hit_clr;
    logic                 row_en;
    logic [NUM_SLOTS-1:0] row_d;

    always_comb begin
      hit_set = set_en && (set_level == LVL_W'(g));
      hit_clr = clr_en && (clr_level == LVL_W'(g));
      row_en  = hit_set || hit_clr;
      row_d   = pend[g];
      if (hit_set) row_d = row_d | set_mask;
      if (hit_clr) row_d = row_d & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend[g] <= '0;
      else if (row_en) pend[g] <= row_d;
    end
  end
endmodule

// File: rtl/arb_slot_pick.sv
module arb_slot_pick #(
  parameter int NUM_SLOTS = arb_pkg::DEF_SLOTS,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] active,
  output logic                 hit,
  output logic [SLOT_W-1:0]    slot
);
  always_comb begin
    hit  = |active;
    slot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (active[i]) slot = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/arb_level_pick.sv
module arb_level_pick #(
  parameter int NUM_LEVELS = arb_pkg::DEF_LEVELS,
  parameter int NUM_SLOTS  = arb_pkg::DEF_SLOTS,
  localparam int LVL_W  = $clog2(NUM_LEVELS),
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_LEVELS-1:0]              level_hit,
  input  logic [NUM_LEVELS-1:0][SLOT_W-1:0]  level_slot,
  output logic                               any,
  output logic [LVL_W-1:0]                   win_level,
  output logic [SLOT_W-1:0]                  win_slot
);
  always_comb begin
    any       = |level_hit;
    win_level = '0;
    win_slot  = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (level_hit[i]) begin
        win_level = LVL_W'(i);
        win_slot  = level_slot[i];
      end
    end
  end
endmodule

// File: rtl/bus_req_arbiter.sv
module bus_req_arbiter #(
  parameter int NUM_LEVELS  = arb_pkg::DEF_LEVELS,
  parameter int NUM_SLOTS   = arb_pkg::DEF_SLOTS,
  parameter int INTR_OFFSET = arb_pkg::INTR_OFFSET,
  localparam int LVL_W   = $clog2(NUM_LEVELS),
  localparam int SLOT_W  = $clog2(NUM_SLOTS),
  localparam int ILVL_W  = $clog2(NUM_LEVELS + INTR_OFFSET),
  localparam int DMA_IDX = NUM_LEVELS - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_set,
  input  logic [LVL_W-1:0]     req_level,
  input  logic [SLOT_W-1:0]    req_slot,
  input  logic                 complete,
  output logic                 grant_valid,
  output logic [LVL_W-1:0]     grant_level,
  output logic [SLOT_W-1:0]    grant_slot,
  output logic [NUM_SLOTS-1:0] grant_slot_onehot,
  output logic [ILVL_W-1:0]    grant_intr_level,
  output logic                 grant_is_dma
);
  logic [NUM_LEVELS-1:0][NUM_SLOTS-1:0] pend;
  logic [NUM_LEVELS*NUM_SLOTS-1:0]      pend_flat;
  logic [NUM_LEVELS-1:0]                lvl_hit;
  logic [NUM_LEVELS-1:0][SLOT_W-1:0]    lvl_slot;
  logic                                 sel_any;
  logic [LVL_W-1:0]                     sel_level;
  logic [SLOT_W-1:0]                    sel_slot;

  logic                 gnt_valid_q, gnt_valid_d;
  logic [LVL_W-1:0]     gnt_level_q, gnt_level_d;
  logic [SLOT_W-1:0]    gnt_slot_q,  gnt_slot_d;
  logic [NUM_SLOTS-1:0] gnt_oh_q,    gnt_oh_d;
  logic                 gnt_en;
  logic                 retire;

  assign retire    = gnt_valid_q && complete;
  assign pend_flat = pend;

  arb_pending_bank #(.NUM_LEVELS(NUM_LEVELS), .NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (req_set),
    .set_level (req_level),
    .set_slot  (req_slot),
    .clr_en    (retire),
    .clr_level (gnt_level_q),
    .clr_slot  (gnt_slot_q),
    .pend      (pend)
  );

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_enc
    arb_slot_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
      .active (pend[g]),
      .hit    (lvl_hit[g]),
      .slot   (lvl_slot[g])
    );
  end

  arb_level_pick #(.NUM_LEVELS(NUM_LEVELS), .NUM_SLOTS(NUM_SLOTS)) u_lvl (
    .level_hit  (lvl_hit),
    .level_slot (lvl_slot),
    .any        (sel_any),
    .win_level  (sel_level),
    .win_slot   (sel_slot)
  );

  // Next-state: retire on complete, load when idle, otherwise hold.
  always_comb begin
    gnt_en      = retire || !gnt_valid_q;
    gnt_valid_d = 1'b0;
    gnt_level_d = '0;
    gnt_slot_d  = '0;
    gnt_oh_d    = '0;
    if (!gnt_valid_q && sel_any) begin
      gnt_valid_d = 1'b1;
      gnt_level_d = sel_level;
      gnt_slot_d  = sel_slot;
      gnt_oh_d    = NUM_SLOTS'(1) << sel_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid_q <= 1'b0;
      gnt_level_q <= '0;
      gnt_slot_q  <= '0;
      gnt_oh_q    <= '0;
    end else if (gnt_en) begin
      gnt_valid_q <= gnt_valid_d;
      gnt_level_q <= gnt_level_d;
      gnt_slot_q  <= gnt_slot_d;
      gnt_oh_q    <= gnt_oh_d;
    end
  end

  always_comb begin
    grant_valid       = gnt_valid_q;
    grant_level       = gnt_level_q;
    grant_slot        = gnt_slot_q;
    grant_slot_onehot = gnt_oh_q;
    grant_is_dma      = gnt_valid_q && (gnt_level_q == LVL_W'(DMA_IDX));
    grant_intr_level  = '0;
    if (gnt_valid_q && !grant_is_dma)
      grant_intr_level = ILVL_W'(gnt_level_q) + ILVL_W'(INTR_OFFSET);
  end
endmodule

// File: rtl/bus_req_arbiter_chk.sv
module bus_req_arbiter_chk #(
  parameter int NUM_LEVELS  = arb_pkg::DEF_LEVELS,
  parameter int NUM_SLOTS   = arb_pkg::DEF_SLOTS,
  parameter int INTR_OFFSET = arb_pkg::INTR_OFFSET,
  localparam int LVL_W  = $clog2(NUM_LEVELS),
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int ILVL_W = $clog2(NUM_LEVELS + INTR_OFFSET)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            complete,
  input logic                            grant_valid,
  input logic [LVL_W-1:0]                grant_level,
  input logic [SLOT_W-1:0]               grant_slot,
  input logic [NUM_SLOTS-1:0]            grant_slot_onehot,
  input logic [ILVL_W-1:0]               grant_intr_level,
  input logic                            grant_is_dma,
  input logic [NUM_LEVELS*NUM_SLOTS-1:0] pend_flat
);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant_level == '0 && grant_slot == '0 &&
                      grant_slot_onehot == '0 && grant_intr_level == '0 && !grant_is_dma));

  p_onehot_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($countones(grant_slot_onehot) == 1 && grant_slot_onehot[grant_slot]));

  p_intr_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_level < LVL_W'(NUM_LEVELS - 1)) |->
      (!grant_is_dma && int'(grant_intr_level) == int'(grant_level) + INTR_OFFSET));

  p_dma_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_level == LVL_W'(NUM_LEVELS - 1)) |->
      (grant_is_dma && grant_intr_level == '0));

  p_grant_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> pend_flat[int'(grant_level) * NUM_SLOTS + int'(grant_slot)]);

  p_empty_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flat == '0) |=> !grant_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !complete) |=>
      (grant_valid && $stable(grant_level) && $stable(grant_slot)));

  p_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && complete) |=>
      (!grant_valid && !pend_flat[int'($past(grant_level)) * NUM_SLOTS + int'($past(grant_slot))]));
endmodule

bind bus_req_arbiter bus_req_arbiter_chk #(
  .NUM_LEVELS(NUM_LEVELS), .NUM_SLOTS(NUM_SLOTS), .INTR_OFFSET(INTR_OFFSET)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .complete          (complete),
  .grant_valid       (grant_valid),
  .grant_level       (grant_level),
  .grant_slot        (grant_slot),
  .grant_slot_onehot (grant_slot_onehot),
  .grant_intr_level  (grant_intr_level),
  .grant_is_dma      (grant_is_dma),
  .pend_flat         (pend_flat)
);

// File: tb/tb_bus_req_arbiter.sv
module tb_bus_req_arbiter;
  logic        clk;
  logic        rst_n;
  logic        req_set;
  logic [2:0]  req_level;
  logic [4:0]  req_slot;
  logic        complete;
  logic        grant_valid;
  logic [2:0]  grant_level;
  logic [4:0]  grant_slot;
  logic [31:0] grant_slot_onehot;
  logic [3:0]  grant_intr_level;
  logic        grant_is_dma;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bus_req_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_level(req_level),
    .req_slot(req_slot), .complete(complete), .grant_valid(grant_valid),
    .grant_level(grant_level), .grant_slot(grant_slot),
    .grant_slot_onehot(grant_slot_onehot), .grant_intr_level(grant_intr_level),
    .grant_is_dma(grant_is_dma)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Each entry: three requests {valid,level[2:0],slot[4:0]}, then expected {level,slot}.
  localparam logic [34:0] VEC [0:7] = '{
    {9'h100 | {1'b0,3'd1,5'd5},  9'h100 | {1'b0,3'd1,5'd2},  9'h100 | {1'b0,3'd1,5'd9},  {3'd1,5'd2}},
    {9'h100 | {1'b0,3'd0,5'd3},  9'h100 | {1'b0,3'd3,5'd20}, 9'h100 | {1'b0,3'd2,5'd1},  {3'd3,5'd20}},
    {9'h100 | {1'b0,3'd4,5'd30}, 9'h100 | {1'b0,3'd3,5'd0},  9'h100 | {1'b0,3'd0,5'd0},  {3'd4,5'd30}},
    {9'h100 | {1'b0,3'd2,5'd7},  9'h100 | {1'b0,3'd2,5'd7},  9'h000,                     {3'd2,5'd7}},
    {9'h100 | {1'b0,3'd0,5'd1},  9'h100 | {1'b0,3'd0,5'd0},  9'h100 | {1'b0,3'd0,5'd2},  {3'd0,5'd0}},
    {9'h100 | {1'b0,3'd4,5'd10}, 9'h100 | {1'b0,3'd4,5'd4},  9'h100 | {1'b0,3'd4,5'd31}, {3'd4,5'd4}},
    {9'h100 | {1'b0,3'd3,5'd31}, 9'h100 | {1'b0,3'd1,5'd0},  9'h000,                     {3'd3,5'd31}},
    {9'h100 | {1'b0,3'd0,5'd17}, 9'h100 | {1'b0,3'd0,5'd15}, 9'h000,                     {3'd0,5'd15}}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Called at a negedge; returns at the negedge after the capturing edge.
  task automatic set_req(input logic [2:0] l, input logic [4:0] s);
    req_set = 1'b1; req_level = l; req_slot = s;
    @(negedge clk);
    req_set = 1'b0; req_level = '0; req_slot = '0;
  endtask

  task automatic pulse_complete();
    complete = 1'b1;
    @(negedge clk);
    complete = 1'b0;
  endtask

  task automatic check_grant(input string req, input int l, input int s);
    chk({req, " valid"}, int'(grant_valid), 1);
    chk({req, " level"}, int'(grant_level), l);
    chk({req, " slot"},  int'(grant_slot), s);
  endtask

  task automatic drain();
    for (int k = 0; k < 12; k++) begin
      if (grant_valid) pulse_complete();
      else @(negedge clk);
    end
    chk("R6 drained idle", int'(grant_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_set = 1'b0; req_level = '0; req_slot = '0; complete = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid in reset", int'(grant_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid", int'(grant_valid), 0);
    chk("R1 level", int'(grant_level), 0);
    chk("R1 slot", int'(grant_slot), 0);
    chk("R1 onehot", int'(grant_slot_onehot), 0);
    chk("R1 intr", int'(grant_intr_level), 0);

    // Table walk: blocker grant at level 0 slot 16, load requests (R5), then retire it.
    for (int v = 0; v < 8; v++) begin
      logic [34:0] e;
      int el, es;
      e = VEC[v];
      set_req(3'd0, 5'd16);
      @(negedge clk);
      check_grant("R4 blocker", 0, 16);
      for (int r = 0; r < 3; r++) begin
        logic [8:0] q;
        q = e[34 - 9*r -: 9];
        if (q[8]) set_req(q[7:5], q[4:0]);
      end
      check_grant("R5 no preemption", 0, 16);
      pulse_complete();
      chk("R6 grant dropped", int'(grant_valid), 0);
      @(negedge clk);
      el = int'(e[7:5]);
      es = int'(e[4:0]);
      check_grant("R2 R3 winner", el, es);
      chk("R9 intr level", int'(grant_intr_level), (el < 4) ? el + 4 : 0);
      chk("R9 dma flag", int'(grant_is_dma), (el == 4) ? 1 : 0);
      chk("R10 onehot", int'(grant_slot_onehot == (32'd1 << es)), 1);
      drain();
    end

    // R4: latency of one edge after the capturing edge
    set_req(3'd2, 5'd3);
    chk("R4 not same edge", int'(grant_valid), 0);
    @(negedge clk);
    check_grant("R4 next edge", 2, 3);
    chk("R8 onehot", int'(grant_slot_onehot), 32'h8);

    // R6: retire with another pending request
    set_req(3'd1, 5'd6);
    pulse_complete();
    chk("R6 drop", int'(grant_valid), 0);
    chk("R8 idle level", int'(grant_level), 0);
    chk("R8 idle slot", int'(grant_slot), 0);
    @(negedge clk);
    check_grant("R6 next winner", 1, 6);
    chk("R9 intr five", int'(grant_intr_level), 5);
    drain();

    // R7: repeated set while granted, one complete removes it
    set_req(3'd1, 5'd1);
    set_req(3'd1, 5'd1);
    set_req(3'd1, 5'd1);
    check_grant("R7 granted", 1, 1);
    pulse_complete();
    repeat (3) @(negedge clk);
    chk("R7 no second grant", int'(grant_valid), 0);

    // R11: complete with no grant outstanding, same cycle as a set of level 0 slot 0
    complete = 1'b1;
    set_req(3'd0, 5'd0);
    complete = 1'b0;
    chk("R11 idle", int'(grant_valid), 0);
    @(negedge clk);
    check_grant("R11 request survives", 0, 0);
    chk("R9 intr four", int'(grant_intr_level), 4);
    drain();

    // R2: DMA over level 7 with simultaneous pending
    set_req(3'd3, 5'd0);
    @(negedge clk);
    set_req(3'd4, 5'd31);
    pulse_complete();
    @(negedge clk);
    check_grant("R2 dma wins", 4, 31);
    chk("R9 dma", int'(grant_is_dma), 1);
    drain();

    finish_run();
  end
endmodule